// File: doc/BRIEF.md
# Conditional Priority Interrupt Requester

This block raises the interrupt request of a multi-port serial card. Each port reports two kinds of events: a byte has arrived, and a byte has finished shifting out. Software can also force a transmit event for any port. Every event is held in its own pending flag. The block then takes one flag at a time, always the highest-priority one, and turns it into a request to the host. A request starts only when four things hold together: interrupts are enabled, the upstream daisy-chain input is idle, a flag is pending, and the processor's current level is strictly below the card's programmed level.

The host services a request in three steps. While the request is raised, the level bus stays undriven. When the host acknowledges, the block drives the level bus with its programmed level. When the host reads the card's status, the request drops and the level bus is released. During the request, the status word identifies the source being serviced by port number and direction. Events that arrive during a request are kept pending and are serviced later. A clear command discards all pending events and returns the block to idle.

Top module: `irq_requester`

## Requirements
- R1: After reset, `intrq_o` is 0, `level_oe_o` is 0, `level_o` is 0 and `stat_o` is 0. Interrupts start disabled, and the programmed level starts at `LVL_RST` (6 by default).
- R2: A receive pulse on port p sets the pending flag of source p. A transmit pulse on port p sets the pending flag of source NUM_PORTS+p. A software trigger sets the flag of source NUM_PORTS+`sw_tx_port_i`. A flag stays set until it is granted or cleared, including while interrupts are disabled.
- R3: At a rising edge where the block is idle, interrupts are enabled, a flag is pending, `chain_busy_i` is 0 and `cpu_level_i` < programmed level, the block grants: `intrq_o` is 1 after that edge and the granted flag is cleared. An event sampled at edge k can therefore raise `intrq_o` after edge k+1 at the earliest.
- R4: While `chain_busy_i` is 1, or while `cpu_level_i` is greater than or equal to the programmed level (equality included), no new request starts.
- R5: `level_oe_o` and `level_o` stay 0 while a request waits for acknowledge. After the edge that samples `int_ack_i`, `level_oe_o` is 1 and `level_o` equals the programmed level.
- R6: `stat_o` is {1, dir, port} while a request is active and 0 when idle. Bit PORT_W+1 is the valid bit, bit PORT_W is the direction (0 receive, 1 transmit), and the low PORT_W bits hold the port number. A status read during a request drops `intrq_o` and `level_oe_o` after the next edge.
- R7: When several flags are pending, the lowest source index is granted first: all receive sources in ascending port order, then all transmit sources in ascending port order.
- R8: An event that arrives while a request is active is latched. If it is for the same source, it is served again once the current request is cleared.
- R9: When interrupts are disabled, no request starts. If interrupts are disabled before acknowledge, the request is withdrawn and its source becomes pending again. If enable and disable are given in the same cycle, the block ends up disabled.
- R10: A level write changes both the threshold used for the processor-level comparison and the value driven on `level_o` after acknowledge.
- R11: A clear command empties every pending flag, including events that arrive in the same cycle, and returns the block to idle. The enable state and the programmed level are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_done_i | input | NUM_PORTS | Per-port byte-received pulses |
| tx_done_i | input | NUM_PORTS | Per-port byte-sent pulses |
| sw_tx_trig_i | input | 1 | Software transmit-interrupt trigger |
| sw_tx_port_i | input | PORT_W | Port addressed by the software trigger |
| int_en_i | input | 1 | Enable-interrupts command |
| int_dis_i | input | 1 | Disable-interrupts command |
| clr_i | input | 1 | Clear command: drop pending events, return to idle |
| lvl_wr_i | input | 1 | Level register write strobe |
| lvl_wdata_i | input | LVL_W | Level register write data |
| chain_busy_i | input | 1 | Upstream daisy-chain interrupt active |
| cpu_level_i | input | LVL_W | Current processor level |
| int_ack_i | input | 1 | Host interrupt acknowledge |
| stat_rd_i | input | 1 | Status-read strobe; clears the request |
| intrq_o | output | 1 | Interrupt request |
| level_oe_o | output | 1 | Level bus is being driven |
| level_o | output | LVL_W | Level bus value, 0 when not driven |
| stat_o | output | PORT_W+2 | Source identification {valid, dir, port} |

## Verification
The bench builds the block with its default parameters: four ports, which gives eight sources and a 3-bit source index, and a 4-bit level that resets to 6. With a 4-bit level, the processor level can sit on either side of the threshold and exactly on it, both at the reset value and after level writes of 3 and of random values. Level 0 is included, and it blocks every request. With eight sources, the full ordering is exercised: receive before transmit and ascending port order. The bench also covers the withdraw-and-restore path on disable, and a clear that arrives together with new events.

// File: rtl/irq_req_pkg.sv
package irq_req_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_ACKED = 2'd2
  } irq_state_e;

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int LVL_W   = 4,
  parameter int LVL_RST = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_cmd_i,
  input  logic             dis_cmd_i,
  input  logic             lvl_wr_i,
  input  logic [LVL_W-1:0] lvl_wdata_i,
  output logic             en_q_o,
  output logic [LVL_W-1:0] lvl_q_o
);

  logic             en_q, en_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;

  always_comb begin
    en_d = en_q;
    if (dis_cmd_i)     en_d = 1'b0;
    else if (en_cmd_i) en_d = 1'b1;
  end

  always_comb begin
    lvl_d = lvl_q;
    if (lvl_wr_i) lvl_d = lvl_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      lvl_q <= LVL_W'(LVL_RST);
    end else begin
      en_q  <= en_d;
      lvl_q <= lvl_d;
    end
  end

  assign en_q_o  = en_q;
  assign lvl_q_o = lvl_q;

  // R9
  dis_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_cmd_i |=> !en_q);

  // R10
  lvl_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_wr_i |=> (lvl_q == $past(lvl_wdata_i)));

endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int NSRC  = 8,
  parameter int SRC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [NSRC-1:0]  set_i,
  input  logic             take_i,
  input  logic [SRC_W-1:0] take_idx_i,
  input  logic             restore_i,
  input  logic [SRC_W-1:0] restore_idx_i,
  output logic [NSRC-1:0]  pend_o
);

  logic [NSRC-1:0] pend_q, pend_d;
  logic [NSRC-1:0] take_mask, restore_mask;

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      assign take_mask[i]    = take_i    && (take_idx_i    == SRC_W'(i));
      assign restore_mask[i] = restore_i && (restore_idx_i == SRC_W'(i));

      // R2
      set_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_i[i] && !clr_i) |=> pend_q[i]);
    end
  endgenerate

  always_comb begin
    if (clr_i) pend_d = '0;
    else       pend_d = (pend_q & ~take_mask) | set_i | restore_mask;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  // R11
  clr_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (pend_q == '0));

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NSRC  = 8,
  parameter int SRC_W = 3
) (
  input  logic [NSRC-1:0]  req_i,
  output logic             any_o,
  output logic [SRC_W-1:0] idx_o
);

  logic [NSRC:0]   seen;
  logic [NSRC-1:0] hit;

  assign seen[0] = 1'b0;

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_chain
      assign hit[i]      = req_i[i] & ~seen[i];
      assign seen[i + 1] = seen[i] | req_i[i];
    end
  endgenerate

  assign any_o = seen[NSRC];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (hit[i]) idx_o = idx_o | SRC_W'(i);
    end
  end

endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer
  import irq_req_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int LVL_W     = 4,
  parameter int SRC_W     = 3,
  parameter int PORT_W    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic              any_pend_i,
  input  logic [SRC_W-1:0]  pick_idx_i,
  input  logic              chain_busy_i,
  input  logic [LVL_W-1:0]  cpu_lvl_i,
  input  logic [LVL_W-1:0]  lvl_i,
  input  logic              ack_i,
  input  logic              stat_rd_i,
  output logic              take_o,
  output logic              restore_o,
  output logic [SRC_W-1:0]  cap_idx_o,
  output logic              req_o,
  output logic              drive_o,
  output logic              src_dir_o,
  output logic [PORT_W-1:0] src_port_o
);

  localparam logic [SRC_W-1:0] NP = SRC_W'(NUM_PORTS);

  irq_state_e       state_q, state_d;
  logic [SRC_W-1:0] cap_q;
  logic             may_grant;

  assign may_grant = en_i && any_pend_i && !chain_busy_i && (cpu_lvl_i < lvl_i);

  always_comb begin
    state_d   = state_q;
    take_o    = 1'b0;
    restore_o = 1'b0;
    if (clr_i) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (may_grant) begin
            state_d = ST_REQ;
            take_o  = 1'b1;
          end
        end
        ST_REQ: begin
          if (stat_rd_i) begin
            state_d = ST_IDLE;
          end else if (!en_i) begin
            state_d   = ST_IDLE;
            restore_o = 1'b1;
          end else if (ack_i) begin
            state_d = ST_ACKED;
          end
        end
        ST_ACKED: begin
          if (stat_rd_i) state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cap_q <= '0;
    else if (take_o) cap_q <= pick_idx_i;
  end

  assign cap_idx_o  = cap_q;
  assign req_o      = (state_q != ST_IDLE);
  assign drive_o    = (state_q == ST_ACKED);
  assign src_dir_o  = (cap_q >= NP);
  assign src_port_o = PORT_W'((cap_q >= NP) ? (cap_q - NP) : cap_q);

  // R3
  grant_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $past(en_i && !chain_busy_i && (cpu_lvl_i < lvl_i) && any_pend_i));

  // R4
  lvl_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_IDLE) && ((cpu_lvl_i >= lvl_i) || chain_busy_i)) |=> !req_o);

  // R5
  drive_after_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drive_o) |-> $past(ack_i));

  // R6
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && stat_rd_i) |=> (!req_o && !drive_o));

endmodule

// File: rtl/irq_requester.sv
module irq_requester #(
  parameter int NUM_PORTS = 4,
  parameter int LVL_W     = 4,
  parameter int LVL_RST   = 6,
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_PORTS-1:0] rx_done_i,
  input  logic [NUM_PORTS-1:0] tx_done_i,
  input  logic              sw_tx_trig_i,
  input  logic [PORT_W-1:0] sw_tx_port_i,
  input  logic              int_en_i,
  input  logic              int_dis_i,
  input  logic              clr_i,
  input  logic              lvl_wr_i,
  input  logic [LVL_W-1:0]  lvl_wdata_i,
  input  logic              chain_busy_i,
  input  logic [LVL_W-1:0]  cpu_level_i,
  input  logic              int_ack_i,
  input  logic              stat_rd_i,
  output logic              intrq_o,
  output logic              level_oe_o,
  output logic [LVL_W-1:0]  level_o,
  output logic [PORT_W+1:0] stat_o
);

  localparam int NSRC  = 2 * NUM_PORTS;
  localparam int SRC_W = $clog2(NSRC);

  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  logic [NSRC-1:0]  set_vec;
  logic [NSRC-1:0]  pend;
  logic             en_q;
  logic [LVL_W-1:0] lvl_q;
  logic             any_pend;
  logic [SRC_W-1:0] pick_idx;
  logic             take, restore, req, drive, src_dir;
  logic [SRC_W-1:0] cap_idx;
  logic [PORT_W-1:0] src_port;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      assign set_vec[p]             = rx_done_i[p];
      assign set_vec[NUM_PORTS + p] = tx_done_i[p] |
                                      (sw_tx_trig_i && (sw_tx_port_i == PORT_W'(p)));
    end
  endgenerate

  irq_cfg_regs #(.LVL_W(LVL_W), .LVL_RST(LVL_RST)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_core_n),
    .en_cmd_i   (int_en_i),
    .dis_cmd_i  (int_dis_i),
    .lvl_wr_i   (lvl_wr_i),
    .lvl_wdata_i(lvl_wdata_i),
    .en_q_o     (en_q),
    .lvl_q_o    (lvl_q)
  );

  irq_pend_bank #(.NSRC(NSRC), .SRC_W(SRC_W)) u_bank (
    .clk_i        (clk_i),
    .rst_ni       (rst_core_n),
    .clr_i        (clr_i),
    .set_i        (set_vec),
    .take_i       (take),
    .take_idx_i   (pick_idx),
    .restore_i    (restore),
    .restore_idx_i(cap_idx),
    .pend_o       (pend)
  );

  irq_prio_pick #(.NSRC(NSRC), .SRC_W(SRC_W)) u_pick (
    .req_i(pend),
    .any_o(any_pend),
    .idx_o(pick_idx)
  );

  irq_sequencer #(
    .NUM_PORTS(NUM_PORTS), .LVL_W(LVL_W), .SRC_W(SRC_W), .PORT_W(PORT_W)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_core_n),
    .clr_i       (clr_i),
    .en_i        (en_q),
    .any_pend_i  (any_pend),
    .pick_idx_i  (pick_idx),
    .chain_busy_i(chain_busy_i),
    .cpu_lvl_i   (cpu_level_i),
    .lvl_i       (lvl_q),
    .ack_i       (int_ack_i),
    .stat_rd_i   (stat_rd_i),
    .take_o      (take),
    .restore_o   (restore),
    .cap_idx_o   (cap_idx),
    .req_o       (req),
    .drive_o     (drive),
    .src_dir_o   (src_dir),
    .src_port_o  (src_port)
  );

  assign intrq_o    = req;
  assign level_oe_o = drive;
  assign level_o    = drive ? lvl_q : '0;
  assign stat_o     = req ? {1'b1, src_dir, src_port} : '0;

endmodule

// File: tb/irq_requester_bench.sv
module irq_requester_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] rx = '0, tx = '0;
  logic sw = 1'b0;
  logic [1:0] sw_port = '0;
  logic en_c = 1'b0, dis_c = 1'b0, clr = 1'b0, lvl_wr = 1'b0;
  logic [3:0] lvl_wd = '0;
  logic chain = 1'b0;
  logic [3:0] cpu = '0;
  logic ack = 1'b0, srd = 1'b0;
  logic intrq, loe;
  logic [3:0] lvl_out;
  logic [3:0] stat;

  int vectors = 0, miscomp = 0, cyc = 0, rel = 0;
  bit cmp_on = 1'b0;
  string cur_req = "R1";

  bit [7:0] mpend;
  int mst, mcap, mlvl;
  bit men;

  irq_requester u_irq_requester (
    .clk_i(clk), .rst_ni(rst_n), .rx_done_i(rx), .tx_done_i(tx),
    .sw_tx_trig_i(sw), .sw_tx_port_i(sw_port), .int_en_i(en_c), .int_dis_i(dis_c),
    .clr_i(clr), .lvl_wr_i(lvl_wr), .lvl_wdata_i(lvl_wd), .chain_busy_i(chain),
    .cpu_level_i(cpu), .int_ack_i(ack), .stat_rd_i(srd), .intrq_o(intrq),
    .level_oe_o(loe), .level_o(lvl_out), .stat_o(stat)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic model_reset();
    mpend = '0; mst = 0; mcap = 0; mlvl = 6; men = 1'b0;
  endtask

  task automatic model_step();
    bit [7:0] s;
    int lo;
    s = '0;
    for (int p = 0; p < NP; p++) begin
      if (rx[p]) s[p] = 1'b1;
      if (tx[p]) s[NP + p] = 1'b1;
      if (sw && (int'(sw_port) == p)) s[NP + p] = 1'b1;
    end
    if (clr) begin
      mpend = '0; mst = 0;
    end else begin
      lo = -1;
      for (int i = 7; i >= 0; i--) if (mpend[i]) lo = i;
      if (mst == 0) begin
        if (men && lo >= 0 && !chain && int'(cpu) < mlvl) begin
          mcap = lo; mpend[lo] = 1'b0; mst = 1;
        end
      end else if (mst == 1) begin
        if (srd) mst = 0;
        else if (!men) begin mst = 0; mpend[mcap] = 1'b1; end
        else if (ack) mst = 2;
      end else if (srd) begin
        mst = 0;
      end
      mpend = mpend | s;
    end
    if (dis_c) men = 1'b0;
    else if (en_c) men = 1'b1;
    if (lvl_wr) mlvl = int'(lvl_wd);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin rel = 0; model_reset(); end
    else if (rel < 2) begin rel++; model_reset(); end
    else model_step();
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscomp);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      miscomp++;
      $display("FAIL watchdog (all R) cycles=%0d expected below %0d", cyc, WATCHDOG);
      summary();
      $finish;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      int e_rq, e_oe, e_lv, e_st;
      e_rq = (mst != 0) ? 1 : 0;
      e_oe = (mst == 2) ? 1 : 0;
      e_lv = (mst == 2) ? mlvl : 0;
      e_st = (mst != 0) ? (8 + mcap) : 0;
      vectors++;
      if (int'(intrq) != e_rq || int'(loe) != e_oe || int'(lvl_out) != e_lv ||
          int'(stat) != e_st) begin
        miscomp++;
        $display("FAIL %s model: intrq=%0d/%0d oe=%0d/%0d lvl=%0d/%0d stat=%0d/%0d",
                 cur_req, intrq, e_rq, loe, e_oe, lvl_out, e_lv, stat, e_st);
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscomp++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) begin
      @(posedge clk);
      #1;
      rx = '0; tx = '0; sw = 1'b0; en_c = 1'b0; dis_c = 1'b0; clr = 1'b0;
      lvl_wr = 1'b0; ack = 1'b0; srd = 1'b0;
    end
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(4);
    cmp_on = 1'b1;

    cur_req = "R1";
    chk("R1 intrq", int'(intrq), 0);
    chk("R1 level_oe", int'(loe), 0);
    chk("R1 level", int'(lvl_out), 0);
    chk("R1 stat", int'(stat), 0);

    cur_req = "R9";
    rx[2] = 1'b1; tick(); tick(3);
    chk("R9 disabled no request", int'(intrq), 0);

    cur_req = "R3";
    en_c = 1'b1; tick(); tick();
    chk("R3 grant", int'(intrq), 1);
    chk("R6 stat rx port2", int'(stat), 10);
    chk("R5 no drive before ack", int'(loe), 0);
    cur_req = "R5";
    ack = 1'b1; tick();
    chk("R5 drive", int'(loe), 1);
    chk("R5 level value", int'(lvl_out), 6);
    cur_req = "R6";
    srd = 1'b1; tick();
    chk("R6 cleared", int'(intrq), 0);
    chk("R6 released", int'(loe), 0);

    cur_req = "R4";
    cpu = 4'd7;
    tx[1] = 1'b1; rx[3] = 1'b1; rx[1] = 1'b1; tick(); tick(2);
    chk("R4 cpu above", int'(intrq), 0);
    cpu = 4'd6; tick(2);
    chk("R4 cpu equal", int'(intrq), 0);
    cur_req = "R7";
    cpu = 4'd5; tick();
    chk("R7 first rx1", int'(stat), 9);
    srd = 1'b1; tick(); tick();
    chk("R7 then rx3", int'(stat), 11);
    srd = 1'b1; tick(); tick();
    chk("R7 then tx1", int'(stat), 13);
    srd = 1'b1; tick();

    cur_req = "R4";
    chain = 1'b1; rx[0] = 1'b1; tick(); tick(2);
    chk("R4 chain busy", int'(intrq), 0);
    cur_req = "R3";
    chain = 1'b0; tick();
    chk("R3 after chain idle", int'(stat), 8);

    cur_req = "R8";
    rx[0] = 1'b1; rx[2] = 1'b1; tick();
    ack = 1'b1; tick();
    srd = 1'b1; tick(); tick();
    chk("R8 same source again", int'(stat), 8);
    srd = 1'b1; tick(); tick();
    chk("R8 later source", int'(stat), 10);
    srd = 1'b1; tick();

    cur_req = "R9";
    tx[3] = 1'b1; tick(); tick();
    chk("R9 tx3 request", int'(stat), 15);
    dis_c = 1'b1; tick(); tick();
    chk("R9 withdrawn", int'(intrq), 0);
    en_c = 1'b1; tick(); tick();
    chk("R9 restored source", int'(stat), 15);
    srd = 1'b1; tick();
    en_c = 1'b1; dis_c = 1'b1; tick();
    rx[1] = 1'b1; tick(); tick(2);
    chk("R9 disable wins", int'(intrq), 0);
    en_c = 1'b1; tick(); tick();
    chk("R9 held event served", int'(stat), 9);
    srd = 1'b1; tick();

    cur_req = "R10";
    lvl_wr = 1'b1; lvl_wd = 4'd3; cpu = 4'd3; tick();
    rx[2] = 1'b1; tick(); tick(2);
    chk("R10 new threshold blocks", int'(intrq), 0);
    cpu = 4'd2; tick();
    chk("R10 grant below", int'(stat), 10);
    ack = 1'b1; tick();
    chk("R10 driven level", int'(lvl_out), 3);
    srd = 1'b1; tick();

    cur_req = "R11";
    cpu = 4'd7;
    rx[0] = 1'b1; tx[2] = 1'b1; tick();
    clr = 1'b1; rx[3] = 1'b1; tick();
    cpu = 4'd0; tick(3);
    chk("R11 flushed", int'(intrq), 0);
    cur_req = "R2";
    sw = 1'b1; sw_port = 2'd3; tick(); tick();
    chk("R2 software trigger", int'(stat), 15);
    ack = 1'b1; tick();
    chk("R11 level kept", int'(lvl_out), 3);
    srd = 1'b1; tick();

    cur_req = "R3";
    lvl_wr = 1'b1; lvl_wd = 4'd6; tick();
    for (int k = 0; k < 3000; k++) begin
      rx = ($urandom_range(0, 3) == 0) ? 4'($urandom) : '0;
      tx = ($urandom_range(0, 3) == 0) ? 4'($urandom) : '0;
      sw = ($urandom_range(0, 9) == 0);
      sw_port = 2'($urandom);
      en_c = ($urandom_range(0, 7) == 0);
      dis_c = ($urandom_range(0, 19) == 0);
      clr = ($urandom_range(0, 59) == 0);
      lvl_wr = ($urandom_range(0, 49) == 0);
      lvl_wd = 4'($urandom_range(0, 9));
      chain = ($urandom_range(0, 4) == 0);
      cpu = 4'($urandom_range(0, 8));
      ack = ($urandom_range(0, 2) == 0);
      srd = ($urandom_range(0, 3) == 0);
      tick();
    end
    tick(2);
    summary();
    $finish;
  end

endmodule